// File: doc/BRIEF.md
# Interrupt Entry Stack Frame Sequencer

This block performs the memory traffic and register updates that accompany a transfer into an interrupt or exception handler, and the matching return. On entry it takes a snapshot of the interrupted context (stack segment, stack pointer, flags, code selector and instruction pointer). If the handler runs at a more privileged level, it switches to the stack that a per-level table holds for that level. It then writes a frame of 32-bit words through a single stack port and finally hands back the handler's selector, entry offset and adjusted flags.

On return it reads the frame back through the same port and restores the interrupted context. It first steps over an error-code word when told to. When the restored code selector shows a different privilege level from the current one, it also reads back the old stack pointer and stack segment. Descriptor lookup and permission checks stay with the surrounding logic. The block only sequences the frame, one stack word per cycle, and reports through `busy` and a one-cycle `done`.

States: `ST_IDLE` (waiting), `ST_SWAP` (load the target level's stack), `ST_PUSH` (one word written per cycle), `ST_DROP` (skip an error code), `ST_POP` (one word read per cycle) and `ST_LOAD` (publish the results). Transitions:
- `ST_IDLE`→`ST_SWAP` on an entry that changes level.
- `ST_IDLE`→`ST_PUSH` on an entry without a level change.
- `ST_IDLE`→`ST_DROP` on a return with the discard flag set.
- `ST_IDLE`→`ST_POP` on a return without the discard flag.
- `ST_SWAP`→`ST_PUSH`.
- `ST_PUSH`→`ST_LOAD` after the last word.
- `ST_DROP`→`ST_POP`.
- `ST_POP`→`ST_LOAD` after the flags word when the level is unchanged, or after the stack-segment word when it changed.
- `ST_LOAD`→`ST_IDLE`.

Top module: `intr_frame_seq`

## Requirements
- R1: While reset is held low, and in the first cycle after it, `busy`, `done`, `mem_we` and `mem_re` are all 0.
- R2: On an entry whose target level (`ent_lvl`) is not numerically below the current level (`cur_cs[1:0]`), three words are pushed on the current stack in the order flags, code selector, instruction pointer. Selectors are zero-extended to 32 bits, each slot is 4 bytes, and the final `new_esp` is `cur_esp` minus 4 per pushed word.
- R3: When `ent_has_err` is 1, `ent_err` is pushed as one extra word after the instruction pointer, at the lowest address of the frame.
- R4: When `ent_lvl` is numerically below `cur_cs[1:0]`, the stack segment and pointer are taken from the table entry for that level before any push. Level n sits at `ring_ss_tab[16n+15:16n]` and `ring_esp_tab[32n+31:32n]`. `new_ss` reports that segment.
- R5: After a stack switch, five words are pushed on the new stack in the order old stack segment, old stack pointer, flags, code selector, instruction pointer. The optional error code follows them.
- R6: At the end of an entry, `new_cs` equals `ent_sel` and `new_eip` equals `ent_off`.
- R7: An entry with `ent_trap` = 0 gives `new_eflags` with bit 9 (interrupt enable) cleared. With `ent_trap` = 1, `new_eflags` equals `cur_eflags`. The pushed flags word is always the unmodified `cur_eflags`.
- R8: A push writes at the stack pointer minus 4 and leaves the pointer there. A pop reads at the pointer and then adds 4. Consecutive pushes therefore use addresses 4 apart going down, and consecutive pops use addresses 4 apart going up. The write and read strobes are never active together.
- R9: A return reads the instruction pointer, code selector and flags from the stack top, in that order, and reports them on `new_eip`, `new_cs` and `new_eflags`. With no level change, `new_ss` is `cur_ss` and `new_esp` points just above the flags word.
- R10: On a return where the low two bits of the restored selector differ from `cur_cs[1:0]`, two further words are read: the stack pointer and then the stack segment. These become `new_esp` and `new_ss`.
- R11: With `ret_drop_err` = 1, the stack pointer is advanced by 4 before the first read, so the error-code word is skipped.
- R12: `busy` is 1 from the cycle after a request is taken until the results are published. `done` is high for exactly one cycle, with `busy` low and the results valid. From the accepting edge, `done` rises after (1 if switching) + (words pushed) + 1 further edges on entry, and after (1 if discarding) + (words read) + 1 further edges on return.
- R13: If `ent_req` and `ret_req` are both high in the idle state, the entry is performed and the return request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_req | input | 1 | Start an entry sequence (taken when idle) |
| ent_trap | input | 1 | 1 = trap-style gate (flags kept), 0 = interrupt-style gate |
| ent_lvl | input | 2 | Privilege level of the handler |
| ent_sel | input | 16 | Handler code selector |
| ent_off | input | 32 | Handler entry offset |
| ent_has_err | input | 1 | An error code is pushed |
| ent_err | input | 32 | Error code value |
| ret_req | input | 1 | Start a return sequence (taken when idle) |
| ret_drop_err | input | 1 | Skip one error-code word before reading the frame |
| cur_ss | input | 16 | Current stack segment |
| cur_esp | input | 32 | Current stack pointer |
| cur_eflags | input | 32 | Current flags |
| cur_cs | input | 16 | Current code selector (low two bits = current level) |
| cur_eip | input | 32 | Current instruction pointer |
| ring_ss_tab | input | 48 | Per-level stack segments, levels 0 to 2 |
| ring_esp_tab | input | 96 | Per-level stack pointers, levels 0 to 2 |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | 32 | Stack byte address |
| mem_wdata | output | 32 | Stack write data |
| mem_rdata | input | 32 | Stack read data, same cycle as `mem_re` |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| new_ss | output | 16 | Resulting stack segment |
| new_esp | output | 32 | Resulting stack pointer |
| new_eflags | output | 32 | Resulting flags |
| new_cs | output | 16 | Resulting code selector |
| new_eip | output | 32 | Resulting instruction pointer |

## Verification
The embedded properties watch the stack port on every cycle. They check that write and read strobes are exclusive, that push addresses step down by one slot and pop addresses step up by one, and that `done` is a lone pulse outside `busy`. On each completed entry they also check the handler selector and offset and the interrupt-enable bit. Frame order, the choice of stack from the level table, error-code placement and skipping, and the full round trip back to the interrupted context can only be shown by the bench. Its scenarios compare memory contents and final register values against a reference model, for random and directed level combinations.

// File: rtl/intr_frame_pkg.sv
package intr_frame_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SWAP,
        ST_PUSH,
        ST_DROP,
        ST_POP,
        ST_LOAD
    } seq_state_t;

    localparam int IF_POS   = 9;
    localparam int SLOT_B   = 4;
    localparam int IDX_W    = 3;

    // frame word index; push order runs upward, pop order reuses 0..4
    localparam logic [IDX_W-1:0] IX_SS   = 3'd0;
    localparam logic [IDX_W-1:0] IX_ESP  = 3'd1;
    localparam logic [IDX_W-1:0] IX_FL   = 3'd2;
    localparam logic [IDX_W-1:0] IX_CS   = 3'd3;
    localparam logic [IDX_W-1:0] IX_EIP  = 3'd4;
    localparam logic [IDX_W-1:0] IX_ERR  = 3'd5;

    localparam logic [IDX_W-1:0] PX_EIP  = 3'd0;
    localparam logic [IDX_W-1:0] PX_CS   = 3'd1;
    localparam logic [IDX_W-1:0] PX_FL   = 3'd2;
    localparam logic [IDX_W-1:0] PX_ESP  = 3'd3;
    localparam logic [IDX_W-1:0] PX_SS   = 3'd4;
endpackage

// File: rtl/ring_stack_pick.sv
module ring_stack_pick #(
    parameter int NLVL  = 3,
    parameter int SEL_W = 16,
    parameter int W     = 32
) (
    input  logic [1:0]            lvl,
    input  logic [NLVL*SEL_W-1:0] ss_tab,
    input  logic [NLVL*W-1:0]     esp_tab,
    output logic [SEL_W-1:0]      ss_o,
    output logic [W-1:0]          esp_o
);
    logic [SEL_W-1:0] ss_a  [NLVL];
    logic [W-1:0]     esp_a [NLVL];

    for (genvar g = 0; g < NLVL; g++) begin : g_unpack
        assign ss_a[g]  = ss_tab[g*SEL_W +: SEL_W];
        assign esp_a[g] = esp_tab[g*W +: W];
    end

    always_comb begin
        ss_o  = '0;
        esp_o = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (int'(lvl) == i) begin
                ss_o  = ss_a[i];
                esp_o = esp_a[i];
            end
        end
    end
endmodule

// File: rtl/frame_word_mux.sv
module frame_word_mux
    import intr_frame_pkg::*;
#(
    parameter int SEL_W = 16,
    parameter int W     = 32
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [SEL_W-1:0] ss,
    input  logic [W-1:0]     esp,
    input  logic [W-1:0]     fl,
    input  logic [SEL_W-1:0] cs,
    input  logic [W-1:0]     eip,
    input  logic [W-1:0]     err,
    output logic [W-1:0]     word
);
    localparam int PAD = W - SEL_W;

    always_comb begin
        unique case (idx)
            IX_SS:   word = {{PAD{1'b0}}, ss};
            IX_ESP:  word = esp;
            IX_FL:   word = fl;
            IX_CS:   word = {{PAD{1'b0}}, cs};
            IX_EIP:  word = eip;
            IX_ERR:  word = err;
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/intr_frame_seq.sv
module intr_frame_seq
    import intr_frame_pkg::*;
#(
    parameter int NLVL  = 3,
    parameter int SEL_W = 16,
    parameter int W     = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ent_req,
    input  logic                  ent_trap,
    input  logic [1:0]            ent_lvl,
    input  logic [SEL_W-1:0]      ent_sel,
    input  logic [W-1:0]          ent_off,
    input  logic                  ent_has_err,
    input  logic [W-1:0]          ent_err,
    input  logic                  ret_req,
    input  logic                  ret_drop_err,
    input  logic [SEL_W-1:0]      cur_ss,
    input  logic [W-1:0]          cur_esp,
    input  logic [W-1:0]          cur_eflags,
    input  logic [SEL_W-1:0]      cur_cs,
    input  logic [W-1:0]          cur_eip,
    input  logic [NLVL*SEL_W-1:0] ring_ss_tab,
    input  logic [NLVL*W-1:0]     ring_esp_tab,
    output logic                  mem_we,
    output logic                  mem_re,
    output logic [W-1:0]          mem_addr,
    output logic [W-1:0]          mem_wdata,
    input  logic [W-1:0]          mem_rdata,
    output logic                  busy,
    output logic                  done,
    output logic [SEL_W-1:0]      new_ss,
    output logic [W-1:0]          new_esp,
    output logic [W-1:0]          new_eflags,
    output logic [SEL_W-1:0]      new_cs,
    output logic [W-1:0]          new_eip
);
    localparam logic [W-1:0] STEP = W'(SLOT_B);

    seq_state_t state, nxt;

    logic [SEL_W-1:0] snap_ss, snap_cs, stk_ss, gate_sel, pick_ss;
    logic [W-1:0]     snap_esp, snap_fl, snap_eip, snap_err, sp, gate_off, pick_esp;
    logic [IDX_W-1:0] idx, push_last;
    logic [1:0]       lvl_q, cpl_q;
    logic             trap_q, has_err_q, xfer, is_ret, ent_xfer;

    assign ent_xfer  = ent_lvl < cur_cs[1:0];
    assign push_last = has_err_q ? IX_ERR : IX_EIP;

    ring_stack_pick #(.NLVL(NLVL), .SEL_W(SEL_W), .W(W)) u_pick (
        .lvl     (lvl_q),
        .ss_tab  (ring_ss_tab),
        .esp_tab (ring_esp_tab),
        .ss_o    (pick_ss),
        .esp_o   (pick_esp)
    );

    frame_word_mux #(.SEL_W(SEL_W), .W(W)) u_mux (
        .idx  (idx),
        .ss   (snap_ss),
        .esp  (snap_esp),
        .fl   (snap_fl),
        .cs   (snap_cs),
        .eip  (snap_eip),
        .err  (snap_err),
        .word (mem_wdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (ent_req)      nxt = ent_xfer ? ST_SWAP : ST_PUSH;
                else if (ret_req) nxt = ret_drop_err ? ST_DROP : ST_POP;
            end
            ST_SWAP: nxt = ST_PUSH;
            ST_PUSH: nxt = (idx == push_last) ? ST_LOAD : ST_PUSH;
            ST_DROP: nxt = ST_POP;
            ST_POP: begin
                if (idx == PX_SS)
                    nxt = ST_LOAD;
                else if (idx == PX_FL && snap_cs[1:0] == cpl_q)
                    nxt = ST_LOAD;
            end
            ST_LOAD: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // stack port
    assign busy     = (state != ST_IDLE);
    assign mem_we   = (state == ST_PUSH);
    assign mem_re   = (state == ST_POP);
    assign mem_addr = (state == ST_PUSH) ? sp - STEP : sp;

    // datapath and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_ss <= '0;  snap_esp <= '0; snap_fl <= '0; snap_cs <= '0;
            snap_eip <= '0; snap_err <= '0; sp <= '0;      stk_ss <= '0;
            gate_sel <= '0; gate_off <= '0; idx <= '0;     lvl_q <= '0;
            cpl_q <= '0;    trap_q <= 1'b0; has_err_q <= 1'b0;
            xfer <= 1'b0;   is_ret <= 1'b0; done <= 1'b0;
            new_ss <= '0;   new_esp <= '0;  new_eflags <= '0;
            new_cs <= '0;   new_eip <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (ent_req) begin
                        snap_ss   <= cur_ss;     snap_esp <= cur_esp;
                        snap_fl   <= cur_eflags; snap_cs  <= cur_cs;
                        snap_eip  <= cur_eip;    snap_err <= ent_err;
                        sp        <= cur_esp;    stk_ss   <= cur_ss;
                        gate_sel  <= ent_sel;    gate_off <= ent_off;
                        trap_q    <= ent_trap;   has_err_q <= ent_has_err;
                        lvl_q     <= ent_lvl;    xfer     <= ent_xfer;
                        idx       <= ent_xfer ? IX_SS : IX_FL;
                        is_ret    <= 1'b0;
                    end else if (ret_req) begin
                        sp     <= cur_esp;
                        stk_ss <= cur_ss;
                        cpl_q  <= cur_cs[1:0];
                        idx    <= PX_EIP;
                        xfer   <= 1'b0;
                        is_ret <= 1'b1;
                    end
                end
                ST_SWAP: begin
                    sp     <= pick_esp;
                    stk_ss <= pick_ss;
                end
                ST_PUSH: begin
                    sp  <= sp - STEP;
                    idx <= idx + 1'b1;
                end
                ST_DROP: sp <= sp + STEP;
                ST_POP: begin
                    sp  <= sp + STEP;
                    idx <= idx + 1'b1;
                    unique case (idx)
                        PX_EIP: snap_eip <= mem_rdata;
                        PX_CS:  snap_cs  <= mem_rdata[SEL_W-1:0];
                        PX_FL: begin
                            snap_fl <= mem_rdata;
                            xfer    <= (snap_cs[1:0] != cpl_q);
                        end
                        PX_ESP: snap_esp <= mem_rdata;
                        PX_SS:  snap_ss  <= mem_rdata[SEL_W-1:0];
                        default: ;
                    endcase
                end
                ST_LOAD: begin
                    done <= 1'b1;
                    if (is_ret) begin
                        new_eip    <= snap_eip;
                        new_cs     <= snap_cs;
                        new_eflags <= snap_fl;
                        new_esp    <= xfer ? snap_esp : sp;
                        new_ss     <= xfer ? snap_ss  : stk_ss;
                    end else begin
                        new_eip    <= gate_off;
                        new_cs     <= gate_sel;
                        new_esp    <= sp;
                        new_ss     <= stk_ss;
                        new_eflags <= trap_q ? snap_fl
                                             : (snap_fl & ~(W'(1) << IF_POS));
                    end
                end
                default: ;
            endcase
        end
    end

    // embedded properties
    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R8
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - STEP)); // R8
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + STEP)); // R8
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R12
    AST_GATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_ret) |-> (new_cs == gate_sel && new_eip == gate_off)); // R6
    AST_IF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_ret && !trap_q) |-> !new_eflags[IF_POS]); // R7
    AST_IF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_ret && trap_q) |-> (new_eflags[IF_POS] == snap_fl[IF_POS])); // R7
endmodule

// File: tb/sim_intr_frame_seq.sv
module sim_intr_frame_seq;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, ent_req, ent_trap, ent_has_err, ret_req, ret_drop_err;
    logic [1:0]  ent_lvl;
    logic [15:0] ent_sel, cur_ss, cur_cs;
    logic [31:0] ent_off, ent_err, cur_esp, cur_eflags, cur_eip;
    logic [47:0] ring_ss_tab;
    logic [95:0] ring_esp_tab;
    logic        mem_we, mem_re, busy, done;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [15:0] new_ss, new_cs;
    logic [31:0] new_esp, new_eflags, new_eip;

    logic [31:0] mem [0:255];
    always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    assign mem_rdata = mem[mem_addr[9:2]];

    intr_frame_seq u0 (
        .clk(clk), .rst_n(rst_n), .ent_req(ent_req), .ent_trap(ent_trap),
        .ent_lvl(ent_lvl), .ent_sel(ent_sel), .ent_off(ent_off),
        .ent_has_err(ent_has_err), .ent_err(ent_err), .ret_req(ret_req),
        .ret_drop_err(ret_drop_err), .cur_ss(cur_ss), .cur_esp(cur_esp),
        .cur_eflags(cur_eflags), .cur_cs(cur_cs), .cur_eip(cur_eip),
        .ring_ss_tab(ring_ss_tab), .ring_esp_tab(ring_esp_tab),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .new_ss(new_ss), .new_esp(new_esp), .new_eflags(new_eflags),
        .new_cs(new_cs), .new_eip(new_eip)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_flags(input logic [31:0] fl, input logic trap);
        return trap ? fl : (fl & ~32'h0000_0200);
    endfunction

    function automatic logic [31:0] tab_esp(input int lvl);
        return ring_esp_tab[lvl*32 +: 32];
    endfunction

    function automatic logic [15:0] tab_ss(input int lvl);
        return ring_ss_tab[lvl*16 +: 16];
    endfunction

    // one entry followed by the matching return; expected values from the requirements
    task automatic run_pair(input logic [15:0] cs, input logic [15:0] ss,
                            input logic [31:0] esp, input logic [31:0] fl,
                            input logic [31:0] eip, input logic [1:0] lvl,
                            input logic trap, input logic herr,
                            input logic [31:0] err, input logic [31:0] off,
                            input logic both);
        logic [31:0] w [6];
        logic [31:0] base, fin_esp;
        logic [15:0] fin_ss, gsel;
        logic        sw;
        int          n, cnt, k;
        sw   = lvl < cs[1:0];
        gsel = {13'($urandom), 1'b0, lvl};
        n = 0;
        if (sw) begin
            w[n] = {16'd0, ss}; n++;
            w[n] = esp;         n++;
        end
        w[n] = fl;             n++;
        w[n] = {16'd0, cs};    n++;
        w[n] = eip;            n++;
        if (herr) begin w[n] = err; n++; end
        base    = sw ? tab_esp(int'(lvl)) : esp;
        fin_esp = base - 32'(4 * n);
        fin_ss  = sw ? tab_ss(int'(lvl)) : ss;

        @(negedge clk);
        cur_cs = cs; cur_ss = ss; cur_esp = esp; cur_eflags = fl; cur_eip = eip;
        ent_lvl = lvl; ent_trap = trap; ent_has_err = herr; ent_err = err;
        ent_sel = gsel; ent_off = off; ent_req = 1'b1; ret_req = both;
        ret_drop_err = 1'b0;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) begin
                ent_req = 1'b0; ret_req = 1'b0;
                chk("R12 busy after entry accept", 32'(busy), 32'd1);
            end
        end while (!done && cnt < 50);
        chk("R12 entry latency", 32'(cnt), 32'((sw ? 1 : 0) + n + 2));
        chk("R12 busy low at done", 32'(busy), 32'd0);
        chk(both ? "R13 entry wins, new_cs" : "R6 new_cs", 32'(new_cs), 32'(gsel));
        chk("R6 new_eip", new_eip, off);
        chk("R7 new_eflags", new_eflags, exp_flags(fl, trap));
        chk(sw ? "R4 new_ss from table" : "R2 new_ss unchanged", 32'(new_ss), 32'(fin_ss));
        chk(sw ? "R5 new_esp" : "R2 new_esp", new_esp, fin_esp);
        for (int i = 0; i < n; i++) begin
            k = int'(base[9:2]) - 1 - i;
            chk((herr && i == n - 1) ? "R3 error code word" : (sw ? "R5 frame word" : "R2 frame word"),
                mem[k[7:0]], w[i]);
        end
        @(negedge clk);
        chk("R12 done one cycle", 32'(done), 32'd0);

        // return
        cur_cs = gsel; cur_ss = fin_ss; cur_esp = fin_esp;
        cur_eflags = $urandom; cur_eip = $urandom;
        ret_req = 1'b1; ret_drop_err = herr;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) ret_req = 1'b0;
        end while (!done && cnt < 50);
        chk(herr ? "R11 return latency with discard" : "R12 return latency",
            32'(cnt), 32'((herr ? 1 : 0) + (sw ? 5 : 3) + 2));
        chk("R9 restored eip", new_eip, eip);
        chk("R9 restored cs", 32'(new_cs), 32'(cs));
        chk("R9 restored eflags", new_eflags, fl);
        chk(sw ? "R10 restored esp" : (herr ? "R11 esp after discard" : "R9 esp"), new_esp, esp);
        chk(sw ? "R10 restored ss" : "R9 ss", 32'(new_ss), 32'(ss));
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        fails++;
        $display("FAIL watchdog actual=%0d expected=completion", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [1:0] cpl, lvl;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; ent_req = 1'b0; ret_req = 1'b0; ret_drop_err = 1'b0;
        ent_trap = 1'b0; ent_lvl = '0; ent_sel = '0; ent_off = '0;
        ent_has_err = 1'b0; ent_err = '0; cur_ss = '0; cur_esp = '0;
        cur_eflags = '0; cur_cs = '0; cur_eip = '0;
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
        ring_ss_tab  = {16'h0033, 16'h0022, 16'h0010};
        ring_esp_tab = {32'h0000_0300, 32'h0000_0200, 32'h0000_0100};
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", 32'(busy), 32'd0);
        chk("R1 done in reset", 32'(done), 32'd0);
        chk("R1 strobes in reset", 32'({mem_we, mem_re}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 32'({busy, done, mem_we, mem_re}), 32'd0);

        // directed corners
        run_pair(16'h0023, 16'h002B, 32'h0000_03C0, 32'h0000_0202, 32'h1000_0040,
                 2'd3, 1'b0, 1'b0, 32'h0, 32'hC000_1000, 1'b0); // same level, interrupt
        run_pair(16'h0023, 16'h002B, 32'h0000_03C0, 32'h0000_0202, 32'h1000_0044,
                 2'd0, 1'b0, 1'b1, 32'h0000_0E0D, 32'hC000_2000, 1'b0); // switch + err
        run_pair(16'h0013, 16'h001B, 32'h0000_0380, 32'h0000_0246, 32'h2000_0000,
                 2'd1, 1'b1, 1'b0, 32'h0, 32'hC000_3000, 1'b0); // trap keeps IF
        run_pair(16'h0008, 16'h0010, 32'h0000_0080, 32'h0000_0002, 32'h3000_0000,
                 2'd0, 1'b0, 1'b1, 32'h0000_0008, 32'hC000_4000, 1'b0); // level 0 + err
        run_pair(16'h0022, 16'h002A, 32'h0000_03F0, 32'h0000_0200, 32'h4000_0000,
                 2'd2, 1'b1, 1'b1, 32'h1234_5678, 32'hC000_5000, 1'b1); // both requests

        // constrained random
        for (int it = 0; it < 60; it++) begin
            ring_ss_tab  = {16'($urandom), 16'($urandom), 16'($urandom)};
            ring_esp_tab = {32'($urandom_range(250, 20)) << 2,
                            32'($urandom_range(250, 20)) << 2,
                            32'($urandom_range(250, 20)) << 2};
            cpl = 2'($urandom_range(3, 0));
            lvl = 2'($urandom_range(int'(cpl), 0));
            run_pair({14'($urandom), cpl}, 16'($urandom),
                     32'($urandom_range(250, 20)) << 2, $urandom, $urandom,
                     lvl, 1'($urandom), 1'($urandom), $urandom, $urandom, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule